// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block sits beside a single load/store request port and only observes it. The requester raises a load or a store request flag and presents an address. The responder drives busy, a one-cycle address accept or address exception, and for loads a one-cycle load-valid. For stores the requester itself pulses store-valid once the address has been accepted. The monitor follows every transaction with a small state machine. Whenever the two sides break the handshake, it records the breach in a sticky per-rule error bit.

Busy does not drop at the same point in every case. Busy falls in the same cycle as a load result or an address exception. After a store, busy falls one cycle after the store-valid pulse. The monitor checks each of these endings separately. It also keeps saturating counts of completed loads, completed stores and exceptions, so that a test environment can compare them against the traffic it generated. The data buses are not observed.

Top module: `ldst_port_monitor`

## Requirements
- R1: A rising edge of the load or store request flag while busy is high sets error bit 0.
- R2: Load request and store request both high in one cycle sets error bit 1.
- R3: Error bit 2 is set in any of these cases:
  - busy is high while no transaction is open;
  - busy is low in the cycle after a request starts a transaction;
  - busy falls before the transaction completes.
- R4: Error bit 3 is set when all of the following hold:
  - a transaction is open;
  - address-valid and busy were both high in the previous cycle;
  - busy is still high;
  - address-valid is now low or the address value has changed.
- R5: Error bit 4 is set in any of these cases:
  - an address accept or exception arrives outside the address phase, which includes a second response in one transaction and a pulse that lasts two cycles;
  - accept and exception arrive together;
  - an exception arrives while busy is still high.

  A well-formed exception with busy low ends the transaction and counts as an exception.
- R6: Error bit 5 is set in any of these cases:
  - load-valid arrives other than while a load waits for its data, after address acceptance;
  - busy is still high in the load-valid cycle.
- R7: Error bit 6 is set in any of these cases:
  - store-valid arrives before address acceptance, during a load, or in the cycle after a store-valid;
  - busy is low in the store-valid cycle;
  - busy is still high in the cycle after store-valid.
- R8: All seven error bits are zero after synchronous reset. Each bit stays set until the next reset. The combined error output is the OR of the seven bits.
- R9: The load, store and exception counters are zero after reset. Each counter increments once per completed load, completed store or exception, and saturates at its all-ones value.
- R10: Well-formed load, store and exception transactions, including ones with idle wait cycles, set no error bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_req | input | 1 | Load request from the requester |
| st_req | input | 1 | Store request from the requester |
| busy | input | 1 | Port busy from the responder |
| addr_vld | input | 1 | Address valid from the requester |
| addr | input | AW | Address from the requester |
| addr_ack | input | 1 | Address accepted pulse from the responder |
| addr_exc | input | 1 | Address exception pulse from the responder |
| ld_vld | input | 1 | Load result valid pulse from the responder |
| st_vld | input | 1 | Store data valid pulse from the requester |
| err_vec | output | 7 | Sticky error bits, bit n per rule as listed in R1 to R7 |
| err_any | output | 1 | OR of all error bits |
| n_loads | output | CW | Saturating count of completed loads |
| n_stores | output | CW | Saturating count of completed stores |
| n_excs | output | CW | Saturating count of address exceptions |

## Verification
The main stimulus consists of short transactions replayed from reset. There are clean loads, stores and exceptions, some stretched with idle wait cycles. Each is paired with a copy that breaks exactly one rule, so every error bit must light alone. The timing variants tell apart busy falling with the response from busy falling one cycle after it, and an early pulse from a doubled one. Longer streams of clean transactions separate the three counters from each other and drive the load counter into saturation. Errors injected before clean traffic show whether the flags persist.

// File: rtl/ldst_port_monitor.sv
module ldst_port_monitor #(
  parameter int AW = 48,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_req,
  input  logic          st_req,
  input  logic          busy,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr,
  input  logic          addr_ack,
  input  logic          addr_exc,
  input  logic          ld_vld,
  input  logic          st_vld,
  output logic [6:0]    err_vec,
  output logic          err_any,
  output logic [CW-1:0] n_loads,
  output logic [CW-1:0] n_stores,
  output logic [CW-1:0] n_excs
);
  localparam int NRULE = 7;
  localparam logic [CW-1:0] CMAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_DRAIN} mon_state_t;

  mon_state_t state, nstate;
  logic is_ld, ld_q, st_q, av_q;
  logic [AW-1:0] addr_q;
  logic [NRULE-1:0] hit;
  logic inc_ld, inc_st, inc_exc, rise;

  assign rise    = (ld_req & ~ld_q) | (st_req & ~st_q);
  assign err_any = |err_vec;

  always_comb begin
    hit     = '0;
    nstate  = state;
    inc_ld  = 1'b0;
    inc_st  = 1'b0;
    inc_exc = 1'b0;
    hit[0]  = rise & busy;
    hit[1]  = ld_req & st_req;
    hit[3]  = (state != S_IDLE) & busy & av_q & (~addr_vld | (addr != addr_q));
    case (state)
      S_IDLE: begin
        hit[2] = busy;
        hit[4] = addr_ack | addr_exc;
        hit[5] = ld_vld;
        hit[6] = st_vld;
        if (rise & ~busy) nstate = S_ADDR;
      end
      S_ADDR: begin
        hit[5] = ld_vld;
        hit[6] = st_vld;
        if (addr_exc) begin
          hit[4]  = busy | addr_ack;
          inc_exc = 1'b1;
          nstate  = S_IDLE;
        end else if (addr_ack) begin
          hit[2] = ~busy;
          nstate = S_DATA;
        end else if (~busy) begin
          hit[2] = 1'b1;
          nstate = S_IDLE;
        end
      end
      S_DATA: begin
        hit[4] = addr_ack | addr_exc;
        if (is_ld) begin
          hit[6] = st_vld;
          if (ld_vld) begin
            hit[5] = busy;
            inc_ld = 1'b1;
            nstate = S_IDLE;
          end else if (~busy) begin
            hit[2] = 1'b1;
            nstate = S_IDLE;
          end
        end else begin
          hit[5] = ld_vld;
          if (st_vld) begin
            hit[6] = ~busy;
            nstate = S_DRAIN;
          end else if (~busy) begin
            hit[2] = 1'b1;
            nstate = S_IDLE;
          end
        end
      end
      default: begin
        hit[4] = addr_ack | addr_exc;
        hit[5] = ld_vld;
        hit[6] = st_vld | busy;
        inc_st = 1'b1;
        nstate = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      is_ld    <= 1'b0;
      ld_q     <= 1'b0;
      st_q     <= 1'b0;
      av_q     <= 1'b0;
      addr_q   <= '0;
      err_vec  <= '0;
      n_loads  <= '0;
      n_stores <= '0;
      n_excs   <= '0;
    end else begin
      state   <= nstate;
      if (state == S_IDLE) is_ld <= ld_req;
      ld_q    <= ld_req;
      st_q    <= st_req;
      av_q    <= addr_vld & busy;
      addr_q  <= addr;
      err_vec <= err_vec | hit;
      if (inc_ld  && n_loads  != CMAX) n_loads  <= n_loads  + 1'b1;
      if (inc_st  && n_stores != CMAX) n_stores <= n_stores + 1'b1;
      if (inc_exc && n_excs   != CMAX) n_excs   <= n_excs   + 1'b1;
    end
  end

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((err_vec & $past(err_vec)) == $past(err_vec)));

  p_ld_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (n_loads == CMAX) |=> (n_loads == CMAX));

  p_ld_count_r6: assert property (@(posedge clk) disable iff (rst)
    !ld_vld |=> $stable(n_loads));

  p_exc_count_r5: assert property (@(posedge clk) disable iff (rst)
    !addr_exc |=> $stable(n_excs));

  p_st_count_r7: assert property (@(posedge clk) disable iff (rst)
    (!st_vld && state != S_DRAIN) |=> $stable(n_stores));
endmodule

// File: tb/test_ldst_port_monitor.sv
module test_ldst_port_monitor;
  localparam int AW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, ld_req, st_req, busy, addr_vld, addr_ack, addr_exc, ld_vld, st_vld;
  logic [AW-1:0] addr;
  logic [6:0] err_vec;
  logic err_any;
  logic [CW-1:0] n_loads, n_stores, n_excs;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  ldst_port_monitor #(.AW(AW), .CW(CW)) i_ldst_port_monitor (
    .clk(clk), .rst(rst), .ld_req(ld_req), .st_req(st_req), .busy(busy),
    .addr_vld(addr_vld), .addr(addr), .addr_ack(addr_ack), .addr_exc(addr_exc),
    .ld_vld(ld_vld), .st_vld(st_vld), .err_vec(err_vec), .err_any(err_any),
    .n_loads(n_loads), .n_stores(n_stores), .n_excs(n_excs)
  );

  // row: [18] rst [17] ld [16] st [15] busy [14] av [13] asel [12] ack [11] exc [10] lv [9] sv [8] chk [7:0] expected
  localparam logic [18:0] RSTR    = 19'b1_0000_0000_00_00000000;
  localparam logic [18:0] IDL     = 19'b0_0000_0000_00_00000000;
  localparam logic [18:0] CHK     = 19'b0_0000_0000_01_00000000;
  localparam logic [18:0] LD_GO   = 19'b0_1001_0000_00_00000000;
  localparam logic [18:0] LD_WAIT = 19'b0_1011_0000_00_00000000;
  localparam logic [18:0] LD_ACK  = 19'b0_1011_0100_00_00000000;
  localparam logic [18:0] LD_DONE = 19'b0_1001_0001_00_00000000;
  localparam logic [18:0] LD_DROP = 19'b0_0011_0000_00_00000000;
  localparam logic [18:0] BOTH_GO = 19'b0_1101_0000_00_00000000;
  localparam logic [18:0] A_MOVE  = 19'b0_1011_1000_00_00000000;
  localparam logic [18:0] A_ACK   = 19'b0_1011_1100_00_00000000;
  localparam logic [18:0] A_DONE  = 19'b0_1001_1001_00_00000000;
  localparam logic [18:0] LD_BUSY = 19'b0_1011_0001_00_00000000;
  localparam logic [18:0] EX_HIT  = 19'b0_1001_0010_00_00000000;
  localparam logic [18:0] ST_GO   = 19'b0_0101_0000_00_00000000;
  localparam logic [18:0] ST_ACK  = 19'b0_0111_0100_00_00000000;
  localparam logic [18:0] ST_HOLD = 19'b0_0111_0000_00_00000000;
  localparam logic [18:0] ST_DAT  = 19'b0_0111_0000_10_00000000;
  localparam logic [18:0] ST_END  = 19'b0_0101_0000_00_00000000;

  localparam int NROW = 58;
  localparam logic [18:0] TBL [NROW] = '{
    RSTR, LD_GO, LD_ACK, LD_DONE, CHK,
    RSTR, ST_GO, ST_ACK, ST_HOLD, ST_DAT, ST_END, CHK,
    RSTR, LD_GO, LD_WAIT, EX_HIT, CHK,
    RSTR, LD_GO, LD_DROP, LD_WAIT, LD_ACK, LD_DONE, CHK | 19'h01,
    RSTR, BOTH_GO, LD_ACK, LD_DONE, CHK | 19'h02,
    RSTR, LD_GO, LD_GO, CHK | 19'h04,
    RSTR, LD_GO, LD_WAIT, A_MOVE, A_ACK, A_DONE, CHK | 19'h08,
    RSTR, LD_GO, LD_ACK, LD_ACK, LD_DONE, CHK | 19'h10,
    RSTR, LD_GO, LD_ACK, LD_BUSY, CHK | 19'h20,
    RSTR, ST_GO, ST_DAT, ST_ACK, ST_DAT, ST_END, CHK | 19'h40
  };

  function automatic string tag_of(input logic [7:0] e);
    case (e)
      8'h01: return "R1";
      8'h02: return "R2";
      8'h04: return "R3";
      8'h08: return "R4";
      8'h10: return "R5";
      8'h20: return "R6";
      8'h40: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [18:0] r);
    rst      = r[18];
    ld_req   = r[17];
    st_req   = r[16];
    busy     = r[15];
    addr_vld = r[14];
    addr     = r[13] ? 16'h00A0 : 16'h0005;
    addr_ack = r[12];
    addr_exc = r[11];
    ld_vld   = r[10];
    st_vld   = r[9];
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load;
    drive(LD_GO); drive(LD_ACK); drive(LD_DONE); drive(IDL);
  endtask

  task automatic do_store;
    drive(ST_GO); drive(ST_ACK); drive(ST_DAT); drive(ST_END); drive(IDL);
  endtask

  task automatic do_exc;
    drive(LD_GO); drive(LD_WAIT); drive(EX_HIT); drive(IDL);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    drive(RSTR);
    drive(RSTR);

    for (int i = 0; i < NROW; i++) begin
      drive(TBL[i]);
      if (TBL[i][8]) begin
        check(tag_of(TBL[i][7:0]), 32'(err_vec), 32'(TBL[i][6:0]));
        check("R8 err_any", 32'(err_any), 32'(|TBL[i][6:0]));
      end
    end

    // R8 / R9 reset state
    drive(RSTR); drive(IDL);
    check("R8 reset err_vec", 32'(err_vec), 32'h0);
    check("R8 reset err_any", 32'(err_any), 32'h0);
    check("R9 reset n_loads", 32'(n_loads), 32'h0);
    check("R9 reset n_stores", 32'(n_stores), 32'h0);
    check("R9 reset n_excs", 32'(n_excs), 32'h0);

    // R9 / R10 mixed clean traffic
    do_load(); do_store(); do_load(); do_exc(); do_store(); do_load();
    check("R9 loads counted", 32'(n_loads), 32'd3);
    check("R9 stores counted", 32'(n_stores), 32'd2);
    check("R9 excs counted", 32'(n_excs), 32'd1);
    check("R10 clean traffic", 32'(err_vec), 32'h0);

    // R9 saturation
    for (int k = 0; k < 14; k++) do_load();
    check("R9 load saturation", 32'(n_loads), 32'd15);
    check("R9 stores untouched", 32'(n_stores), 32'd2);

    // R8 sticky: breach, then clean load, then reset
    drive(19'b0_0000_0000_10_00000000);
    drive(IDL);
    do_load();
    check("R8 sticky bit", 32'(err_vec), 32'h40);
    check("R8 sticky any", 32'(err_any), 32'h1);
    drive(RSTR); drive(IDL);
    check("R8 reset clears", 32'(err_vec), 32'h0);

    // R7 busy held after store data
    drive(RSTR); drive(ST_GO); drive(ST_ACK); drive(ST_DAT); drive(ST_HOLD); drive(IDL);
    check("R7 busy late after store", 32'(err_vec), 32'h40);
    check("R7 store still counted", 32'(n_stores), 32'd1);

    // R7 store-valid on two cycles
    drive(RSTR); drive(ST_GO); drive(ST_ACK); drive(ST_DAT);
    drive(19'b0_0101_0000_10_00000000); drive(IDL);
    check("R7 double store-valid", 32'(err_vec), 32'h40);

    // R7 busy low during store-valid
    drive(RSTR); drive(ST_GO); drive(ST_ACK);
    drive(19'b0_0101_0000_10_00000000); drive(ST_END); drive(IDL);
    check("R7 busy early with store", 32'(err_vec), 32'h40);

    // R3 busy with nothing open
    drive(RSTR); drive(19'b0_0010_0000_00_00000000); drive(IDL);
    check("R3 busy in idle", 32'(err_vec), 32'h04);

    // R3 busy falls while store waits for data
    drive(RSTR); drive(ST_GO); drive(ST_ACK); drive(ST_END); drive(IDL);
    check("R3 busy drops early", 32'(err_vec), 32'h04);

    // R5 exception with busy high
    drive(RSTR); drive(LD_GO); drive(19'b0_1011_0010_00_00000000); drive(IDL);
    check("R5 exception busy high", 32'(err_vec), 32'h10);
    check("R5 exception counted", 32'(n_excs), 32'd1);

    // R5 accept and exception together
    drive(RSTR); drive(LD_GO); drive(19'b0_1001_0110_00_00000000); drive(IDL);
    check("R5 accept with exception", 32'(err_vec), 32'h10);

    // R6 load-valid repeated
    drive(RSTR); drive(LD_GO); drive(LD_ACK); drive(LD_DONE); drive(LD_DONE); drive(IDL);
    check("R6 double load-valid", 32'(err_vec), 32'h20);

    // R6 load-valid during a store
    drive(RSTR); drive(ST_GO); drive(ST_ACK);
    drive(19'b0_0111_0001_00_00000000); drive(ST_DAT); drive(ST_END); drive(IDL);
    check("R6 load-valid in store", 32'(err_vec), 32'h20);

    // R4 address-valid dropped early
    drive(RSTR); drive(LD_GO); drive(LD_WAIT);
    drive(19'b0_1010_0000_00_00000000); drive(LD_ACK); drive(LD_DONE); drive(IDL);
    check("R4 address-valid dropped", 32'(err_vec), 32'h08);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule